// File: doc/BRIEF.md
# Addressed Serial Receiver with Station-ID Filter

This block receives asynchronous serial frames from a line that several stations share. Each frame holds a start bit, eight data bits with the least significant bit first, one address-marker bit and one stop bit. When the marker bit is 1, the payload is a station address. When it is 0, the payload is ordinary data. The line is sampled on a clock enable that runs at sixteen times the bit rate. The block finds each frame's bit centres from that enable alone, so no baud generator is needed inside.

A small state machine decides which frames reach software. After reset, the receiver ignores data frames. It listens only for address frames and compares each one with a station number supplied on an input. An address that matches is handed to software, marked as an address, and opens the receiver for the data frames that follow. An address that does not match closes it again.

Delivered bytes go into a holding register with a ready flag, which a one-cycle clear pulse from software resets. A bad stop bit sets a framing-error flag. A delivery that arrives while the ready flag is still up sets an overrun flag and keeps the older byte. Two request lines, one for receive and one for error, follow these flags.

Top module: `mpc_uart_rx`

## Requirements
- R1: After reset, rx_ready, rx_was_id, frame_err, overrun, rx_irq and err_irq are 0 and rx_data is 0.
- R2: A frame is a 0 start bit, then data bits D0 first to D7 last, then the marker bit, then the stop bit. Each bit lasts 16 tick pulses and is sampled at its centre. The line idles at 1.
- R3: A low pulse shorter than half a bit period is not a start bit. No frame is received and no flag changes.
- R4: From reset until a matching address arrives, frames whose marker bit is 0 are discarded. rx_ready stays unchanged.
- R5: A frame with marker bit 1 whose payload equals station_id is delivered with rx_was_id = 1 and enables reception of data frames.
- R6: A frame with marker bit 1 whose payload differs from station_id is not delivered. Data frames that follow it are discarded until a matching address arrives.
- R7: While enabled, each data frame with a good stop bit is written to rx_data with rx_was_id = 0. It sets rx_ready, and rx_irq follows rx_ready.
- R8: A one-cycle pulse on clr_ready clears rx_ready and rx_irq without changing rx_data.
- R9: A stop bit sampled as 0 sets frame_err and err_irq. The frame is not delivered and the address state is kept. The receiver waits for the line to return to 1 before it looks for a new start bit. clr_err clears frame_err.
- R10: A frame that would be delivered while rx_ready is 1 sets overrun, which also raises err_irq. rx_data and rx_was_id keep the older frame. clr_err clears overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idles high |
| station_id | input | 8 | Address of this station |
| clr_ready | input | 1 | One-cycle pulse that clears rx_ready |
| clr_err | input | 1 | One-cycle pulse that clears frame_err and overrun |
| rx_data | output | 8 | Last delivered payload |
| rx_ready | output | 1 | A delivered payload is waiting |
| rx_was_id | output | 1 | The waiting payload was a matching address |
| frame_err | output | 1 | A stop bit was sampled as 0 |
| overrun | output | 1 | A delivery arrived while rx_ready was set |
| rx_irq | output | 1 | Receive request |
| err_irq | output | 1 | Error request (framing or overrun) |

## Verification
The assertions take station_id to be steady while a frame is in flight, and take rxd to change only on whole bit boundaries of 16 tick pulses, apart from deliberate short glitches on an idle line. The bench keeps tick at one pulse every two clocks. It holds each bit for exactly 32 clocks and leaves two idle bit times between frames. After a bad stop bit it returns the line to 1, so no start bit can be confirmed from a stale low level. Clear pulses are issued only between frames, so the reference model never has to order a clear against a delivery in the same cycle.

// File: rtl/mpc_rx_pkg.sv
package mpc_rx_pkg;

  localparam int unsigned MPC_W = 8;

  typedef enum logic [1:0] {SMP_IDLE, SMP_START, SMP_BITS} smp_state_t;
  typedef enum logic {FLT_HUNT, FLT_OPEN} flt_state_t;

  typedef struct packed {
    flt_state_t nxt;
    logic       hand_over;
  } flt_dec_t;

  // Address-filter decision for one well-formed frame.
  function automatic flt_dec_t flt_decide(input flt_state_t cur, input logic is_addr,
                                          input logic hit);
    flt_dec_t d;
    if (is_addr) begin
      d.nxt       = hit ? FLT_OPEN : FLT_HUNT;
      d.hand_over = hit;
    end else begin
      d.nxt       = cur;
      d.hand_over = (cur == FLT_OPEN);
    end
    return d;
  endfunction

endpackage

// File: rtl/mpc_rx_sampler.sv
module mpc_rx_sampler
  import mpc_rx_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  output logic              fr_done,
  output logic [DATA_W-1:0] fr_data,
  output logic              fr_mark,
  output logic              fr_stop_ok,
  output logic              start_reject
);
  localparam int unsigned CW       = $clog2(OSR);
  localparam int unsigned LAST_BIT = DATA_W + 1;
  localparam int unsigned BW       = $clog2(DATA_W + 2);
  localparam int unsigned HALF     = OSR / 2;

  smp_state_t    st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DATA_W:0] sh;
  logic          armed;

  logic mid_start, bit_smp;
  assign mid_start    = tick && (st == SMP_START) && (cnt == CW'(HALF - 1));
  assign bit_smp      = tick && (st == SMP_BITS) && (cnt == CW'(OSR - 1));
  assign start_reject = mid_start && rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SMP_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      sh         <= '0;
      armed      <= 1'b0;
      fr_done    <= 1'b0;
      fr_stop_ok <= 1'b0;
    end else begin
      fr_done <= 1'b0;
      case (st)
        SMP_IDLE: begin
          if (tick && rxd) armed <= 1'b1;
          if (tick && !rxd && armed) begin
            st  <= SMP_START;
            cnt <= '0;
          end
        end
        SMP_START: begin
          if (tick) begin
            if (cnt == CW'(HALF - 1)) begin
              cnt  <= '0;
              bidx <= '0;
              st   <= rxd ? SMP_IDLE : SMP_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (bit_smp) begin
            cnt <= '0;
            if (bidx == BW'(LAST_BIT)) begin
              fr_done    <= 1'b1;
              fr_stop_ok <= rxd;
              armed      <= rxd;
              st         <= SMP_IDLE;
            end else begin
              sh   <= {rxd, sh[DATA_W:1]};
              bidx <= bidx + 1'b1;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign fr_data = sh[DATA_W-1:0];
  assign fr_mark = sh[DATA_W];

  // R3
  glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> (st == SMP_IDLE) && !fr_done);
  // R2
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done |-> (st == SMP_IDLE) && !$stable(st));
endmodule

// File: rtl/mpc_rx_filter.sv
module mpc_rx_filter
  import mpc_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_done,
  input  logic [DATA_W-1:0] fr_data,
  input  logic              fr_mark,
  input  logic              fr_stop_ok,
  input  logic [DATA_W-1:0] station_id,
  output logic              deliver,
  output logic              deliver_is_id
);
  flt_state_t st;
  flt_dec_t   dec;
  logic       good;

  assign good = fr_done && fr_stop_ok;

  always_comb begin
    dec           = flt_decide(st, fr_mark, fr_data == station_id);
    deliver       = good && dec.hand_over;
    deliver_is_id = fr_mark;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= FLT_HUNT;
    else if (good) st <= dec.nxt;
  end

  // R4
  hunt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && !fr_mark && st == FLT_HUNT) |-> !deliver);
  // R6
  mismatch_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good && fr_mark && fr_data != station_id) |-> !deliver ##1 (st == FLT_HUNT));
  // R5
  match_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good && fr_mark && fr_data == station_id) |=> (st == FLT_OPEN));
  // R9
  bad_stop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && !fr_stop_ok) |-> !deliver ##1 $stable(st));
endmodule

// File: rtl/mpc_rx_status.sv
module mpc_rx_status #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deliver,
  input  logic              deliver_is_id,
  input  logic [DATA_W-1:0] payload,
  input  logic              bad_stop,
  input  logic              clr_ready,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_was_id,
  output logic              frame_err,
  output logic              overrun
);
  logic collide, take;
  assign collide = deliver && rx_ready && !clr_ready;
  assign take    = deliver && !collide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_ready  <= 1'b0;
      rx_was_id <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (take) begin
        rx_data   <= payload;
        rx_was_id <= deliver_is_id;
        rx_ready  <= 1'b1;
      end else if (clr_ready) begin
        rx_ready <= 1'b0;
      end
      if (bad_stop)     frame_err <= 1'b1;
      else if (clr_err) frame_err <= 1'b0;
      if (collide)      overrun <= 1'b1;
      else if (clr_err) overrun <= 1'b0;
    end
  end

  // R7
  store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && !rx_ready) |=> rx_ready && (rx_data == $past(payload)));
  // R10
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> overrun && $stable(rx_data) && $stable(rx_was_id));
  // R8
  clear_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ready && !deliver) |=> !rx_ready && $stable(rx_data));
  // R9
  frame_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_stop |=> frame_err);
endmodule

// File: rtl/mpc_uart_rx.sv
module mpc_uart_rx
  import mpc_rx_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = MPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic [DATA_W-1:0] station_id,
  input  logic              clr_ready,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_was_id,
  output logic              frame_err,
  output logic              overrun,
  output logic              rx_irq,
  output logic              err_irq
);
  logic              fr_done, fr_mark, fr_stop_ok, start_reject;
  logic [DATA_W-1:0] fr_data;
  logic              deliver, deliver_is_id, bad_stop;

  mpc_rx_sampler #(.OSR(OSR), .DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .fr_done(fr_done), .fr_data(fr_data), .fr_mark(fr_mark),
    .fr_stop_ok(fr_stop_ok), .start_reject(start_reject)
  );

  mpc_rx_filter #(.DATA_W(DATA_W)) u_flt (
    .clk(clk), .rst_n(rst_n), .fr_done(fr_done), .fr_data(fr_data),
    .fr_mark(fr_mark), .fr_stop_ok(fr_stop_ok), .station_id(station_id),
    .deliver(deliver), .deliver_is_id(deliver_is_id)
  );

  assign bad_stop = fr_done && !fr_stop_ok;

  mpc_rx_status #(.DATA_W(DATA_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .deliver(deliver), .deliver_is_id(deliver_is_id),
    .payload(fr_data), .bad_stop(bad_stop), .clr_ready(clr_ready),
    .clr_err(clr_err), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_was_id(rx_was_id), .frame_err(frame_err), .overrun(overrun)
  );

  assign rx_irq  = rx_ready;
  assign err_irq = frame_err || overrun;

  // R3
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> $stable(rx_ready) && $stable(frame_err));
  // R1
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready |-> !rx_irq) and (!frame_err && !overrun |-> !err_irq));
endmodule

// File: tb/sim_mpc_uart_rx.sv
module sim_mpc_uart_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] station_id = 8'h5A;
  logic       clr_ready = 1'b0;
  logic       clr_err = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, rx_was_id, frame_err, overrun, rx_irq, err_irq;

  int checks = 0;
  int errors = 0;

  // reference state
  logic       m_open = 1'b0;
  logic       m_ready = 1'b0;
  logic [7:0] m_data = 8'h00;
  logic       m_was_id = 1'b0;
  logic       m_ferr = 1'b0;
  logic       m_ovr = 1'b0;

  always #2 clk = ~clk;

  mpc_uart_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .station_id(station_id),
    .clr_ready(clr_ready), .clr_err(clr_err), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_was_id(rx_was_id), .frame_err(frame_err),
    .overrun(overrun), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  function automatic int rate_of(input bit a, input bit b);
    return (a ? 1 : 0) + (b ? 2 : 0);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " ready"}, rx_ready, m_ready);
    chk({req, " data"}, rx_data, m_data);
    chk({req, " was_id"}, rx_was_id, m_was_id);
    chk({req, " ferr"}, frame_err, m_ferr);
    chk({req, " ovr"}, overrun, m_ovr);
    chk({req, " irqs"}, rate_of(rx_irq, err_irq), rate_of(m_ready, m_ferr || m_ovr));
  endtask

  function automatic void model_frame(input logic [7:0] d, input logic mk, input logic stp);
    logic give;
    give = 1'b0;
    if (!stp) m_ferr = 1'b1;
    else if (mk) begin
      m_open = (d == station_id);
      give   = m_open;
    end else give = m_open;
    if (give) begin
      if (m_ready) m_ovr = 1'b1;
      else begin
        m_ready  = 1'b1;
        m_data   = d;
        m_was_id = mk;
      end
    end
  endfunction

  task automatic drive_bit(input logic b);
    @(negedge clk);
    rxd = b;
    repeat (31) @(negedge clk);
  endtask

  // R2: start 0, D0..D7, marker, stop, then two idle bits
  task automatic send(input logic [7:0] d, input logic mk, input logic stp);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit(mk);
    drive_bit(stp);
    drive_bit(1'b1);
    drive_bit(1'b1);
    model_frame(d, mk, stp);
  endtask

  task automatic pulse_ready();
    @(negedge clk); clr_ready = 1'b1;
    @(negedge clk); clr_ready = 1'b0;
    m_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_err();
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
    m_ferr = 1'b0; m_ovr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk_all("R1 reset");

    send(8'h33, 1'b0, 1'b1); chk_all("R4 data before address");
    send(8'h12, 1'b1, 1'b1); chk_all("R6 mismatched address");
    send(8'h44, 1'b0, 1'b1); chk_all("R6 data after mismatch");
    send(8'h5A, 1'b1, 1'b1); chk_all("R5 matching address");
    chk("R5 was_id", rx_was_id, 1);
    pulse_ready(); chk_all("R8 clear after address");
    send(8'hC3, 1'b0, 1'b1); chk_all("R7 data D0 first");
    chk("R2 bit order", rx_data, 8'hC3);
    send(8'h81, 1'b0, 1'b1); chk_all("R10 overrun keeps old");
    pulse_err(); pulse_ready(); chk_all("R8 R10 clears");

    // R3: short glitch on idle line
    @(negedge clk); rxd = 1'b0;
    repeat (8) @(negedge clk); rxd = 1'b1;
    repeat (600) @(negedge clk);
    chk_all("R3 glitch ignored");

    send(8'h7E, 1'b0, 1'b0); chk_all("R9 bad stop");
    send(8'h19, 1'b0, 1'b1); chk_all("R9 address state kept");
    pulse_err(); pulse_ready(); chk_all("R9 clear error");

    for (int n = 0; n < 80; n++) begin
      logic [7:0] d;
      logic mk, stp;
      mk  = ($urandom % 3) == 0;
      d   = (($urandom % 3) == 0) ? station_id : 8'($urandom);
      stp = ($urandom % 10) != 0;
      send(d, mk, stp);
      chk_all("R2 R4 R5 R6 R7 R9 R10 random");
      if (($urandom % 10) < 6) begin pulse_ready(); chk_all("R8 random clear"); end
      if (($urandom % 2) == 0) pulse_err();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule